// File: doc/BRIEF.md
# Transmit Word Parity Guard

This block sits on the transmit side of a serial link, in front of an 8b/10b encoder. Each clock it takes one input word: eight data bits, two control bits and an odd-parity bit. It checks the word against a parity rule chosen by a two-bit coverage mode and by whether the encoder is in use or bypassed. When the word fails the check, the block raises an error flag. It also asks the downstream path to send a link-violation character in place of the word.

The replacement character depends on the encoder setting. With the encoder in use, the block picks the violation code that matches the running disparity the encoder reports. With the encoder bypassed, it always supplies the positive-disparity form. The check is registered, so the flag, the request and the code appear one clock after the word they describe. The encoder itself is not part of this block.

Top module: `tx_parity_guard`

## Requirements
- R1: Parity is odd. A word passes when the XOR of every covered bit, together with `par_in`, equals 1. Otherwise it fails.
- R2: With `cov_mode` = 2'b00, checking is off. `par_err` stays 0 whatever the data, control and parity inputs are.
- R3: With `cov_mode` = 2'b01 and `enc_en` = 1, only `data_in[7:0]` and `par_in` are covered. `ctl_in` has no effect on the result.
- R4: With `cov_mode` = 2'b10 or 2'b11, `data_in`, `ctl_in` and `par_in` are all covered, whatever the value of `enc_en`.
- R5: With `cov_mode` = 2'b01 and `enc_en` = 0, `data_in`, `ctl_in` and `par_in` are all covered.
- R6: On a failing word with `enc_en` = 1, `sub_code` selects the violation code by running disparity. It is `VIOL_NEG` (default 10'h38B) when `rd_pos` = 0 and `VIOL_POS` (default 10'h074) when `rd_pos` = 1.
- R7: On a failing word with `enc_en` = 0, `sub_code` is `VIOL_POS` whatever the value of `rd_pos`.
- R8: `sub_req` is high in exactly the cycles in which `par_err` is high.
- R9: The outputs describe the word presented one clock earlier. For a passing word, `par_err` and `sub_req` are 0 and `sub_code` is 0.
- R10: While `rst_n` is low at a clock edge, all outputs are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous reset, active low |
| data_in | input | 8 | Transmit data bits |
| ctl_in | input | 2 | Transmit control bits |
| par_in | input | 1 | Odd-parity bit for the word |
| cov_mode | input | 2 | Coverage mode: 00 off, 01 data, 10/11 data and control |
| enc_en | input | 1 | 1 when the encoder is used, 0 when it is bypassed |
| rd_pos | input | 1 | Current running disparity: 1 positive, 0 negative |
| par_err | output | 1 | Parity failure for the previous word |
| sub_req | output | 1 | Request to replace the previous word |
| sub_code | output | 10 | Replacement violation code, 0 when no replacement is requested |

## Verification
A parity failure and the choice of replacement code resolve in the same cycle. That code choice depends on the encoder setting and on the running disparity. The vector table provokes this coincidence with failing words under both disparities with the encoder in use, and under a disparity that should be ignored when the encoder is bypassed. The flag, the request and the code are judged together one clock later against values the bench derives itself. Directed tests then place reset on the same edge as a failing word and expect the failure to be dropped. They also follow a failing word directly with a passing one to show that the flags clear after one cycle.

// File: rtl/txpg_pkg.sv
// Shared types for the transmit parity guard.
// Assumes a two-bit coverage mode; the top value 2'b11 aliases 2'b10.
package txpg_pkg;

    typedef enum logic [1:0] {
        COV_OFF  = 2'b00,
        COV_DATA = 2'b01,
        COV_ALL  = 2'b10,
        COV_ALT  = 2'b11
    } cov_mode_e;

endpackage

// File: rtl/txpg_cover.sv
// Coverage selector and odd-parity evaluator.
// Decides which bits are covered by the mode and the encoder setting,
// then reports whether checking is on and whether the word is odd.
// Assumes purely combinational use; the caller registers the result.
module txpg_cover
    import txpg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CTL_W  = 2
) (
    input  logic [DATA_W-1:0] data,
    input  logic [CTL_W-1:0]  ctl,
    input  logic              par,
    input  cov_mode_e         mode,
    input  logic              enc_en,
    output logic              chk_on,
    output logic              odd_ok
);

    logic with_ctl;

    // Picks the covered set and folds it together with the parity bit.
    always_comb begin
        chk_on   = (mode != COV_OFF);
        with_ctl = (mode == COV_ALL) || (mode == COV_ALT) ||
                   ((mode == COV_DATA) && !enc_en);
        odd_ok   = (^data) ^ par ^ (with_ctl ? (^ctl) : 1'b0);
    end

endmodule

// File: rtl/txpg_vcode.sv
// Violation code selector.
// With the encoder in use the code follows the running disparity;
// when the encoder is bypassed the positive-disparity form is fixed.
module txpg_vcode #(
    parameter int              CODE_W = 10,
    parameter logic [CODE_W-1:0] NEG  = 10'h38B,
    parameter logic [CODE_W-1:0] POS  = 10'h074
) (
    input  logic              enc_en,
    input  logic              rd_pos,
    output logic [CODE_W-1:0] code
);

    // Chooses the replacement code for the present settings.
    always_comb begin
        if (enc_en && !rd_pos) code = NEG;
        else                   code = POS;
    end

endmodule

// File: rtl/tx_parity_guard.sv
// Transmit parity guard, top level.
// Checks odd parity on each word and, on failure, flags the error and
// requests replacement by a violation code. All outputs are registered
// and describe the word seen on the previous clock.
// Assumes a synchronous active-low reset.
module tx_parity_guard
    import txpg_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                CTL_W    = 2,
    parameter int                CODE_W   = 10,
    parameter logic [CODE_W-1:0] VIOL_NEG = 10'h38B,
    parameter logic [CODE_W-1:0] VIOL_POS = 10'h074
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CTL_W-1:0]  ctl_in,
    input  logic              par_in,
    input  logic [1:0]        cov_mode,
    input  logic              enc_en,
    input  logic              rd_pos,
    output logic              par_err,
    output logic              sub_req,
    output logic [CODE_W-1:0] sub_code
);

    localparam logic [CODE_W-1:0] CODE_IDLE = '0;

    cov_mode_e         mode_q;
    logic              chk_on;
    logic              odd_ok;
    logic              fail_d;
    logic [CODE_W-1:0] vcode;

    // Casts the raw mode pins onto the shared enum.
    always_comb mode_q = cov_mode_e'(cov_mode);

    txpg_cover #(
        .DATA_W (DATA_W),
        .CTL_W  (CTL_W)
    ) u_cover (
        .data   (data_in),
        .ctl    (ctl_in),
        .par    (par_in),
        .mode   (mode_q),
        .enc_en (enc_en),
        .chk_on (chk_on),
        .odd_ok (odd_ok)
    );

    txpg_vcode #(
        .CODE_W (CODE_W),
        .NEG    (VIOL_NEG),
        .POS    (VIOL_POS)
    ) u_vcode (
        .enc_en (enc_en),
        .rd_pos (rd_pos),
        .code   (vcode)
    );

    // A word fails only when checking is on and the fold is even.
    always_comb fail_d = chk_on && !odd_ok;

    // Registers the verdict and the replacement code for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_err  <= 1'b0;
            sub_req  <= 1'b0;
            sub_code <= CODE_IDLE;
        end else begin
            par_err  <= fail_d;
            sub_req  <= fail_d;
            sub_code <= fail_d ? vcode : CODE_IDLE;
        end
    end

endmodule

// File: rtl/txpg_checker.sv
// Property checker for the transmit parity guard, bound to the top.
// Relates the registered outputs to the inputs of the previous clock.
module txpg_checker #(
    parameter int                DATA_W = 8,
    parameter int                CTL_W  = 2,
    parameter int                CODE_W = 10,
    parameter logic [CODE_W-1:0] NEG    = 10'h38B,
    parameter logic [CODE_W-1:0] POS    = 10'h074
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] data_in,
    input logic [CTL_W-1:0]  ctl_in,
    input logic              par_in,
    input logic [1:0]        cov_mode,
    input logic              enc_en,
    input logic              rd_pos,
    input logic              par_err,
    input logic              sub_req,
    input logic [CODE_W-1:0] sub_code
);

    // R2: with checking off no error follows.
    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cov_mode) == 2'b00) |-> !par_err);

    // R4: a full-coverage word with odd fold never fails.
    p_full_cover_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cov_mode[1]) && $past((^data_in) ^ (^ctl_in) ^ par_in)) |-> !par_err);

    // R6: encoder in use, code follows running disparity.
    p_enc_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && $past(enc_en)) |-> (sub_code == ($past(rd_pos) ? POS : NEG)));

    // R7: encoder bypassed, positive-disparity code only.
    p_bypass_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && !$past(enc_en)) |-> (sub_code == POS));

    // R8: request and error flag move together.
    p_req_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sub_req == par_err);

    // R9: no error means an idle code.
    p_idle_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !par_err |-> (sub_code == '0));

endmodule

bind tx_parity_guard txpg_checker #(
    .DATA_W (DATA_W),
    .CTL_W  (CTL_W),
    .CODE_W (CODE_W),
    .NEG    (VIOL_NEG),
    .POS    (VIOL_POS)
) u_txpg_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_in  (data_in),
    .ctl_in   (ctl_in),
    .par_in   (par_in),
    .cov_mode (cov_mode),
    .enc_en   (enc_en),
    .rd_pos   (rd_pos),
    .par_err  (par_err),
    .sub_req  (sub_req),
    .sub_code (sub_code)
);

// File: tb/tx_parity_guard_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset and back-to-back words.
module tx_parity_guard_bench;

    localparam int          CLK_PERIOD = 10;
    localparam logic [9:0]  NEG = 10'h38B;
    localparam logic [9:0]  POS = 10'h074;
    localparam int          NVEC = 12;

    typedef struct packed {
        logic [1:0] m;
        logic       e;
        logic       rd;
        logic [1:0] c;
        logic [7:0] d;
        logic       p;
        logic       xe;
        logic [9:0] xc;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 1'b1, 1'b0, 2'b00, 8'h00, 1'b0, 1'b0, 10'h000}, // R2 off
        '{2'b01, 1'b1, 1'b0, 2'b00, 8'h01, 1'b0, 1'b0, 10'h000}, // R1 odd passes
        '{2'b01, 1'b1, 1'b0, 2'b00, 8'h01, 1'b1, 1'b1, NEG},     // R6 rd neg
        '{2'b01, 1'b1, 1'b1, 2'b00, 8'h01, 1'b1, 1'b1, POS},     // R6 rd pos
        '{2'b01, 1'b1, 1'b0, 2'b01, 8'h03, 1'b1, 1'b0, 10'h000}, // R3 ctl ignored
        '{2'b10, 1'b1, 1'b0, 2'b01, 8'h03, 1'b1, 1'b1, NEG},     // R4 ctl covered
        '{2'b11, 1'b0, 1'b0, 2'b11, 8'hFF, 1'b1, 1'b0, 10'h000}, // R4 alias passes
        '{2'b11, 1'b0, 1'b0, 2'b10, 8'hFF, 1'b1, 1'b1, POS},     // R4 R7 alias fails
        '{2'b01, 1'b0, 1'b0, 2'b01, 8'h03, 1'b1, 1'b1, POS},     // R5 R7 bypass
        '{2'b01, 1'b0, 1'b0, 2'b01, 8'h07, 1'b1, 1'b0, 10'h000}, // R5 passes
        '{2'b00, 1'b0, 1'b0, 2'b11, 8'h07, 1'b0, 1'b0, 10'h000}, // R2 off
        '{2'b10, 1'b0, 1'b1, 2'b00, 8'hA5, 1'b0, 1'b1, POS}      // R7 rd ignored
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] data_in;
    logic [1:0] ctl_in;
    logic       par_in;
    logic [1:0] cov_mode;
    logic       enc_en;
    logic       rd_pos;
    logic       par_err;
    logic       sub_req;
    logic [9:0] sub_code;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_parity_guard u_tx_parity_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_in  (data_in),
        .ctl_in   (ctl_in),
        .par_in   (par_in),
        .cov_mode (cov_mode),
        .enc_en   (enc_en),
        .rd_pos   (rd_pos),
        .par_err  (par_err),
        .sub_req  (sub_req),
        .sub_code (sub_code)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        cov_mode = v.m; enc_en = v.e; rd_pos = v.rd;
        ctl_in = v.c; data_in = v.d; par_in = v.p;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        drive(VECS[2]);
        repeat (3) @(negedge clk);
        // R10: reset holds outputs clear even with a failing word present.
        check("R10", {par_err, sub_req, sub_code}, 12'h000);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check("R1-table par_err", {11'b0, par_err}, {11'b0, VECS[i].xe});
            check("R8 sub_req", {11'b0, sub_req}, {11'b0, VECS[i].xe});
            check("R9 sub_code", {2'b0, sub_code}, {2'b0, VECS[i].xc});
        end

        // R9: a failing word followed by a passing one clears after one clock.
        drive(VECS[2]);
        @(negedge clk);
        check("R9 fail cycle", {par_err, sub_req, sub_code}, {2'b11, NEG});
        drive(VECS[1]);
        @(negedge clk);
        check("R9 clear cycle", {par_err, sub_req, sub_code}, 12'h000);

        // R10: reset on the same edge as a failing word drops it.
        drive(VECS[8]);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 overlap", {par_err, sub_req, sub_code}, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 after reset", {par_err, sub_req, sub_code}, {2'b11, POS});

        finish_run();
    end

endmodule